// File: doc/BRIEF.md
# Hough Layer Accumulator

This block performs the forward half of a Hough-transform track finder. Detector hits arrive as angle and reciprocal-radius pairs on one channel per detector layer. For every track-angle column of the parameter space, each accepted hit is mapped to an inverse-momentum row, and the layer's bit is set in the addressed cell of a two-dimensional accumulator. A cell keeps one presence bit per layer instead of a vote count, so repeated hits from one layer never inflate a cell.

When the event-end strobe is accepted, the block stops taking hits and walks the whole array once, one cell per clock. Every cell that holds all layer bits is reported as a candidate road (column, row), with a flag on the final road. Each cell is wiped as it is visited, so when the walk ends the array is empty and hits for the next event are accepted again.

The radius arrives as a precomputed reciprocal. The per-column mapping then needs only a subtraction and a multiplication. Array size, column spacing and fixed-point scaling are parameters.

Top module: `hough_layer_acc`

## Requirements
- R1: While reset is asserted and right after it, `hit_ready` is 1, `road_valid` is 0 and the array is empty.
- R2: Column c has angle c*PHI_STEP. A hit (phi, rinv) maps in column c to row floor(((c*PHI_STEP - phi) * rinv) / 2^FRAC) + ROWS/2. The difference is signed and the floor rounds toward minus infinity. A row outside 0..ROWS-1 changes nothing.
- R3: A hit on channel k sets bit k of every cell it maps to. A later hit from the same channel on the same cell leaves that bit set.
- R4: A cell is reported as a road only when all LAYERS bits are set. A cell missing any one layer is never reported.
- R5: Each channel has its own valid bit, angle and reciprocal. All channels offered in one cycle are accepted together, and all columns are updated in that cycle.
- R6: `evt_end` is taken only while `hit_ready` is 1, and hits offered in the same cycle belong to the ending event. `hit_ready` is then 0 for exactly COLS*ROWS cycles. Hits offered while it is 0 have no effect.
- R7: Cells are visited in column-major order, with column ascending and row ascending within a column. The cell with index col*ROWS+row is visited in the cycle that follows the acceptance edge by that index. A full cell drives `road_valid` with its column and row. `road_last` is 1 only on the final road of the event. An event without roads emits nothing.
- R8: Each visited cell is cleared, so the next event starts from an empty array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_valid | input | LAYERS | Per-channel hit valid, bit k is layer k |
| hit_phi | input | LAYERS*PHI_W | Hit angles, channel k in bits [k*PHI_W +: PHI_W] |
| hit_rinv | input | LAYERS*RINV_W | Reciprocal radii, channel k in bits [k*RINV_W +: RINV_W] |
| hit_ready | output | 1 | Hits and event end are accepted |
| evt_end | input | 1 | Event-end strobe |
| road_valid | output | 1 | A road is presented this cycle |
| road_col | output | COL_W | Track-angle column of the road |
| road_row | output | ROW_W | Inverse-momentum row of the road |
| road_last | output | 1 | Final road of the event |

## Verification
The bench uses the default build: 8 layers, 16 columns, 8 rows, a column step of 256 and 8 fraction bits. With these values a reciprocal of 1 moves a line by one row per column. Steep and flat lines, rows falling off either edge, and single-road and many-road events are all easy to build. A walk takes only 128 cycles, so the bench can run many events and check the exact ready-low window and the last-road flag in each one.

// File: rtl/hough_acc_pkg.sv
package hough_acc_pkg;
  typedef enum logic {
    ST_ACCUM = 1'b0,
    ST_SCAN  = 1'b1
  } acc_state_e;
endpackage

// File: rtl/hough_row_map.sv
// Maps one hit into the row it crosses in one fixed track-angle column.
module hough_row_map #(
  parameter int PHI_W  = 16,
  parameter int RINV_W = 12,
  parameter int ROWS   = 8,
  parameter int FRAC   = 8,
  parameter int PHI0   = 0
) (
  input  logic              en_i,
  input  logic [PHI_W-1:0]  phi_i,
  input  logic [RINV_W-1:0] rinv_i,
  output logic [ROWS-1:0]   hit_o
);
  localparam int PW = PHI_W + RINV_W + 2;
  localparam logic [PHI_W-1:0]     PHI0_V  = PHI_W'(PHI0);
  localparam logic signed [PW-1:0] ROW_OFF = PW'(ROWS / 2);
  localparam logic signed [PW-1:0] ROWS_S  = PW'(ROWS);

  logic signed [PHI_W:0] diff;
  logic signed [PW-1:0]  prod;
  logic signed [PW-1:0]  row_s;
  logic                  in_rng;

  assign diff   = $signed({1'b0, PHI0_V}) - $signed({1'b0, phi_i});
  assign prod   = PW'(diff) * PW'($signed({1'b0, rinv_i}));
  assign row_s  = (prod >>> FRAC) + ROW_OFF;
  assign in_rng = en_i && !row_s[PW-1] && (row_s < ROWS_S);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign hit_o[r] = in_rng && (row_s == $signed(PW'(r)));
  end
endmodule

// File: rtl/hough_cell_array.sv
// Layer-presence storage: sticky set per layer, single-cell clear.
module hough_cell_array #(
  parameter int LAYERS = 8,
  parameter int NCELL  = 128,
  localparam int IDX_W = $clog2(NCELL),
  localparam int BITS  = NCELL * LAYERS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BITS-1:0]  set_i,
  input  logic             clr_en_i,
  input  logic [IDX_W-1:0] clr_idx_i,
  output logic [NCELL-1:0] full_o
);
  logic [BITS-1:0] cell_q;
  logic [BITS-1:0] cell_d;

  always_comb begin
    cell_d = cell_q | set_i;
    if (clr_en_i) begin
      cell_d[clr_idx_i*LAYERS +: LAYERS] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cell_q <= '0;
    end else begin
      cell_q <= cell_d;
    end
  end

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    assign full_o[i] = &cell_q[i*LAYERS +: LAYERS];

    AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      !(clr_en_i && clr_idx_i == IDX_W'(i)) |=>
        ((cell_q[i*LAYERS +: LAYERS] & $past(cell_q[i*LAYERS +: LAYERS]))
          == $past(cell_q[i*LAYERS +: LAYERS])));  // R3
  end

  AST_EMPTY_AFTER_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en_i && clr_idx_i == IDX_W'(NCELL - 1)) |=> (cell_q == '0));  // R8
endmodule

// File: rtl/hough_road_scan.sv
// Event-end walk: column-major visit, road report, clear behind.
module hough_road_scan
  import hough_acc_pkg::*;
#(
  parameter int COLS = 16,
  parameter int ROWS = 8,
  localparam int NCELL = COLS * ROWS,
  localparam int IDX_W = $clog2(NCELL),
  localparam int COL_W = $clog2(COLS),
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_end_i,
  input  logic [NCELL-1:0] full_i,
  output logic             hit_ready_o,
  output logic             clr_en_o,
  output logic [IDX_W-1:0] clr_idx_o,
  output logic             road_valid_o,
  output logic [COL_W-1:0] road_col_o,
  output logic [ROW_W-1:0] road_row_o,
  output logic             road_last_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NCELL - 1);
  localparam logic [IDX_W-1:0] ROWS_I   = IDX_W'(ROWS);

  acc_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             in_scan;
  logic [NCELL-1:0] above;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_ACCUM: begin
        if (evt_end_i) begin
          state_d = ST_SCAN;
          idx_d   = '0;
        end
      end
      ST_SCAN: begin
        if (idx_q == LAST_IDX) begin
          state_d = ST_ACCUM;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: state_d = ST_ACCUM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ACCUM;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign in_scan      = (state_q == ST_SCAN);
  assign hit_ready_o  = !in_scan;
  assign clr_en_o     = in_scan;
  assign clr_idx_o    = idx_q;
  assign above        = ({NCELL{1'b1}} << idx_q) << 1;
  assign road_valid_o = in_scan && full_i[idx_q];
  assign road_col_o   = COL_W'(idx_q / ROWS_I);
  assign road_row_o   = ROW_W'(idx_q % ROWS_I);
  assign road_last_o  = !(|(full_i & above));

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ready_o && evt_end_i) |=> !hit_ready_o);  // R6

  AST_QUIET_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (road_valid_o && road_last_o) |=> !road_valid_o);  // R7
endmodule

// File: rtl/hough_layer_acc.sv
module hough_layer_acc
  import hough_acc_pkg::*;
#(
  parameter int LAYERS   = 8,
  parameter int COLS     = 16,
  parameter int ROWS     = 8,
  parameter int PHI_W    = 16,
  parameter int RINV_W   = 12,
  parameter int PHI_STEP = 256,
  parameter int FRAC     = 8,
  localparam int NCELL = COLS * ROWS,
  localparam int IDX_W = $clog2(NCELL),
  localparam int COL_W = $clog2(COLS),
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LAYERS-1:0]        hit_valid,
  input  logic [LAYERS*PHI_W-1:0]  hit_phi,
  input  logic [LAYERS*RINV_W-1:0] hit_rinv,
  output logic                     hit_ready,
  input  logic                     evt_end,
  output logic                     road_valid,
  output logic [COL_W-1:0]         road_col,
  output logic [ROW_W-1:0]         road_row,
  output logic                     road_last
);
  logic [NCELL*LAYERS-1:0] set_vec;
  logic [NCELL-1:0]        full;
  logic                    clr_en;
  logic [IDX_W-1:0]        clr_idx;
  logic [ROWS-1:0]         map_oh [LAYERS][COLS];

  for (genvar k = 0; k < LAYERS; k++) begin : g_layer
    for (genvar c = 0; c < COLS; c++) begin : g_col
      hough_row_map #(
        .PHI_W  (PHI_W),
        .RINV_W (RINV_W),
        .ROWS   (ROWS),
        .FRAC   (FRAC),
        .PHI0   (c * PHI_STEP)
      ) u_map (
        .en_i   (hit_valid[k] && hit_ready),
        .phi_i  (hit_phi[k*PHI_W +: PHI_W]),
        .rinv_i (hit_rinv[k*RINV_W +: RINV_W]),
        .hit_o  (map_oh[k][c])
      );
      for (genvar r = 0; r < ROWS; r++) begin : g_bit
        assign set_vec[(c*ROWS + r)*LAYERS + k] = map_oh[k][c][r];
      end
    end
  end

  hough_cell_array #(
    .LAYERS (LAYERS),
    .NCELL  (NCELL)
  ) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (set_vec),
    .clr_en_i  (clr_en),
    .clr_idx_i (clr_idx),
    .full_o    (full)
  );

  hough_road_scan #(
    .COLS (COLS),
    .ROWS (ROWS)
  ) u_scan (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_end_i    (evt_end),
    .full_i       (full),
    .hit_ready_o  (hit_ready),
    .clr_en_o     (clr_en),
    .clr_idx_o    (clr_idx),
    .road_valid_o (road_valid),
    .road_col_o   (road_col),
    .road_row_o   (road_row),
    .road_last_o  (road_last)
  );

  AST_NO_SET_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_ready |-> (set_vec == '0));  // R6
endmodule

// File: tb/hough_layer_acc_bench.sv
module hough_layer_acc_bench;
  localparam int L = 8, COLS = 16, ROWS = 8, NCELL = COLS * ROWS;
  localparam int STEP = 256, FRAC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [L-1:0]    v = '0;
  logic [15:0]     ph [L];
  logic [11:0]     ri [L];
  logic            evt = 1'b0;
  logic [L*16-1:0] hit_phi;
  logic [L*12-1:0] hit_rinv;
  logic            hit_ready, road_valid, road_last;
  logic [3:0]      road_col;
  logic [2:0]      road_row;

  int checks = 0, failures = 0;
  int m_cell [NCELL];
  bit m_scan = 0;
  int m_idx = 0;
  int road_q [$];
  bit done = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int k = 0; k < L; k++) begin
      hit_phi[k*16 +: 16]  = ph[k];
      hit_rinv[k*12 +: 12] = ri[k];
    end
  end

  hough_layer_acc u_hough_layer_acc (
    .clk(clk), .rst_n(rst_n), .hit_valid(v), .hit_phi(hit_phi),
    .hit_rinv(hit_rinv), .hit_ready(hit_ready), .evt_end(evt),
    .road_valid(road_valid), .road_col(road_col), .road_row(road_row),
    .road_last(road_last));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_row(input int c, input int phi, input int rinv);
    int p;
    p = (c * STEP - phi) * rinv;
    return (p >>> FRAC) + ROWS / 2;
  endfunction

  // Behavioural reference, updated on every clock edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_scan = 0;
      m_idx  = 0;
      foreach (m_cell[i]) m_cell[i] = 0;
    end else if (m_scan) begin
      m_cell[m_idx] = 0;
      if (m_idx == NCELL - 1) m_scan = 0;
      else m_idx++;
    end else begin
      for (int k = 0; k < L; k++) begin
        if (v[k]) begin
          for (int c = 0; c < COLS; c++) begin
            int r;
            r = exp_row(c, int'(ph[k]), int'(ri[k]));
            if (r >= 0 && r < ROWS) m_cell[c*ROWS + r] |= (1 << k);
          end
        end
      end
      if (evt) begin
        m_scan = 1;
        m_idx  = 0;
      end
    end
  end

  // Per-clock comparison and road capture.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ev, el;
      ev = m_scan && (m_cell[m_idx] == (1 << L) - 1);
      el = 1;
      for (int i = m_idx + 1; i < NCELL; i++)
        if (m_cell[i] == (1 << L) - 1) el = 0;
      chk(hit_ready == !m_scan, "R6", "hit_ready", hit_ready, !m_scan);
      chk(road_valid == ev, "R4", "road_valid", road_valid, ev);
      if (ev && road_valid) begin
        chk(road_col == m_idx / ROWS, "R7", "road_col", road_col, m_idx / ROWS);
        chk(road_row == m_idx % ROWS, "R7", "road_row", road_row, m_idx % ROWS);
        chk(road_last == el, "R7", "road_last", road_last, el);
      end
      if (road_valid) road_q.push_back(road_col * 256 + road_row * 2 + road_last);
    end
  end

  task automatic drive(input logic [L-1:0] vv, input logic e);
    @(negedge clk);
    #1;
    v   = vv;
    evt = e;
  endtask

  task automatic wait_walk(input bit inject, output int cnt);
    @(negedge clk);
    #1;
    v = inject ? '1 : '0;
    evt = inject;
    cnt = 0;
    while (!hit_ready) begin
      cnt++;
      @(negedge clk);
      #1;
    end
    v = '0;
    evt = 1'b0;
  endtask

  task automatic set_all(input int phi, input int rinv);
    for (int k = 0; k < L; k++) begin
      ph[k] = 16'(phi);
      ri[k] = 12'(rinv);
    end
  endtask

  initial begin
    int cnt;
    set_all(0, 0);
    repeat (3) @(negedge clk);
    chk(hit_ready == 1'b1, "R1", "reset hit_ready", hit_ready, 1);
    chk(road_valid == 1'b0, "R1", "reset road_valid", road_valid, 0);
    #1 rst_n = 1'b1;

    // R2/R5: eight lines of rinv 1..8 through (col 5,row 4), all in one cycle.
    for (int k = 0; k < L; k++) begin
      ph[k] = 16'd1280;
      ri[k] = 12'(k + 1);
    end
    road_q.delete();
    drive('1, 1'b0);
    drive('0, 1'b1);
    wait_walk(0, cnt);
    chk(cnt == NCELL, "R6", "ready low cycles", cnt, NCELL);
    chk(road_q.size() == 1, "R2", "single road count", road_q.size(), 1);
    if (road_q.size() > 0)
      chk(road_q[0] == 5*256 + 4*2 + 1, "R5", "single road coords", road_q[0], 5*256 + 9);

    // R4/R3: seven layers only, layer 0 repeated: no road.
    set_all(0, 0);
    road_q.delete();
    drive(8'h7F, 1'b0);
    drive(8'h01, 1'b0);
    drive('0, 1'b1);
    wait_walk(0, cnt);
    chk(road_q.size() == 0, "R4", "seven-layer roads", road_q.size(), 0);

    // R3: layer 3 hits twice before the others; bits stay set.
    road_q.delete();
    drive(8'h08, 1'b0);
    drive(8'h08, 1'b0);
    drive(8'hF7, 1'b1);
    wait_walk(0, cnt);
    chk(road_q.size() == COLS, "R3", "repeat-hit roads", road_q.size(), COLS);

    // R7: layers one per cycle, last with the end strobe; hits during walk ignored.
    road_q.delete();
    for (int k = 0; k < L; k++) drive(L'(1 << k), k == L - 1);
    wait_walk(1, cnt);
    chk(road_q.size() == COLS, "R7", "flat-line roads", road_q.size(), COLS);
    for (int i = 0; i < road_q.size(); i++)
      chk(road_q[i] == i*256 + 4*2 + (i == COLS - 1), "R7", "road order", road_q[i],
          i*256 + 8 + (i == COLS - 1));

    // R8/R6: empty event right after; nothing left behind and nothing injected.
    road_q.delete();
    drive('0, 1'b1);
    wait_walk(0, cnt);
    chk(road_q.size() == 0, "R8", "empty event roads", road_q.size(), 0);
    chk(cnt == NCELL, "R6", "empty walk length", cnt, NCELL);

    // R2: off-range rows from a steep line change nothing.
    set_all(0, 4095);
    road_q.delete();
    drive('1, 1'b1);
    wait_walk(0, cnt);
    chk(road_q.size() == 1, "R2", "steep line roads", road_q.size(), 1);

    // Mixed events: a track plus random noise, compared every clock.
    for (int e = 0; e < 6; e++) begin
      int base;
      base = $urandom_range(0, 3840);
      for (int k = 0; k < L; k++) begin
        ph[k] = 16'(base);
        ri[k] = 12'($urandom_range(0, 6));
      end
      drive('1, 1'b0);
      for (int n = 0; n < 10; n++) begin
        for (int k = 0; k < L; k++) begin
          ph[k] = 16'($urandom_range(0, 4095));
          ri[k] = 12'($urandom_range(0, 20));
        end
        drive(L'($urandom_range(0, 255)), n == 9);
      end
      wait_walk(0, cnt);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    done = 1;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule